// File: doc/BRIEF.md
# Sparse Two-Field Match Combiner

This block turns the per-field lookup results of a two-field packet classifier into one best-matching rule. Each field (source and destination) delivers a short compressed match vector together with the index list that says which rule each compressed bit stands for. The block also holds, in two small internal bit memories, the wildcard mask of each field: one bit per rule, set when that rule accepts any value in the field.

The full match is the AND of two expanded vectors, and each vector is the OR of its compressed part and its wildcard mask. The block never builds those full-width vectors. It evaluates the product as three sparse terms. The first term pairs rules that are listed with set bits in both fields. The second probes the destination wildcard memory only at the rules named by set source bits. The third does the same with the two fields swapped. The term in which a rule is a wildcard in both fields is not evaluated: such rules are served by a configurable default rule. Each term keeps a running lowest rule number. Rules are numbered in decreasing priority, so at the end the lowest of the three minima is reported. When no term yields a candidate, the default rule is reported with the hit flag low.

A lookup is started with a one-cycle strobe. It scans the source slots and then the destination slots, one memory probe per clock, and finishes with a fixed latency.

Top module: `fbe_match_combiner`

## Requirements
- R1: After reset, `done_o` and `hit_o` are 0 and `rule_o` equals `DEFAULT_RULE`.
- R2: A rule listed in a valid source slot whose compressed bit is 1, and also in a valid destination slot whose compressed bit is 1, is a candidate.
- R3: A rule listed in a valid source slot whose compressed bit is 1 is a candidate when its bit in the destination wildcard memory is 1.
- R4: A rule listed in a valid destination slot whose compressed bit is 1 is a candidate when its bit in the source wildcard memory is 1.
- R5: A rule whose wildcard bits are set in both memories, and which is not a candidate by R2 to R4, is never reported with `hit_o` = 1.
- R6: When several candidates exist, `rule_o` is the lowest candidate rule number, whichever term produced it, and `hit_o` = 1.
- R7: With no candidate, `hit_o` = 0 and `rule_o` = `DEFAULT_RULE`.
- R8: A slot whose valid flag is 0, or whose compressed bit is 0, contributes nothing. The rule number stored in that slot does not matter.
- R9: `start_i` is accepted only when the block is idle. `done_o` is then high for exactly one cycle, 2*SLOTS+2 clock edges after the accepting edge. `rule_o` and `hit_o` hold their values until the next result.
- R10: A `start_i` pulse during a lookup is ignored. Inputs that change after the accepting edge do not affect that lookup.
- R11: A write with `dc_we_i` = 1 stores `dc_bit_i` at rule `dc_addr_i` of the source wildcard memory when `dc_dim_i` = 0, or of the destination memory when `dc_dim_i` = 1. Later lookups use the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle strobe that starts a lookup |
| src_bits_i | input | SLOTS | Source compressed match bits, bit x belongs to slot x |
| src_idx_i | input | SLOTS*RW | Source index list, slot x at bits [x*RW +: RW] |
| src_val_i | input | SLOTS | Source slot valid flags |
| dst_bits_i | input | SLOTS | Destination compressed match bits |
| dst_idx_i | input | SLOTS*RW | Destination index list, same packing as source |
| dst_val_i | input | SLOTS | Destination slot valid flags |
| dc_we_i | input | 1 | Wildcard memory write enable |
| dc_dim_i | input | 1 | Memory select: 0 source, 1 destination |
| dc_addr_i | input | RW | Rule number to write |
| dc_bit_i | input | 1 | Wildcard bit to store |
| rule_o | output | RW | Winning rule number, or the default rule |
| hit_o | output | 1 | 1 when an evaluated term produced a candidate |
| done_o | output | 1 | One-cycle pulse when rule_o and hit_o are new |

## Verification
A corrupted running minimum, a dropped probe tag or a probe read from the wrong field's memory would show up at the ports as a wrong rule number or a wrong hit flag on the very `done_o` pulse of the affected lookup. Each lookup's result is compared with a three-term reference. That reference is the AND of the full expanded vectors with only the wildcard-by-wildcard part removed. A miscounted scan shows up in the same lookup as a `done_o` that comes early, comes late or lasts more than one cycle. The sweep reloads both wildcard memories before every lookup, so a memory write that went to the wrong field or rule is caught in the next result.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } fbe_state_t;

  localparam int unsigned TERM_CC = 0;
  localparam int unsigned TERM_CD = 1;
  localparam int unsigned TERM_DC = 2;
  localparam int unsigned NTERMS  = 3;
endpackage

// File: rtl/fbe_dc_ram.sv
module fbe_dc_ram #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_o
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wbit_i;
    rbit_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fbe_min_track.sv
module fbe_min_track #(
  parameter int unsigned RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          offer_i,
  input  logic [RW-1:0] rule_i,
  output logic          found_o,
  output logic [RW-1:0] rule_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      found_o <= 1'b0;
      rule_o  <= '0;
    end else if (offer_i && (!found_o || rule_i < rule_o)) begin
      found_o <= 1'b1;
      rule_o  <= rule_i;
    end
  end

  // R6: a running minimum never grows between clears
  assert_min_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
    (found_o && $past(found_o) && !$past(clr_i)) |-> (rule_o <= $past(rule_o)));
endmodule

// File: rtl/fbe_match_combiner.sv
module fbe_match_combiner
  import fbe_pkg::*;
#(
  parameter int unsigned NRULES       = 16,
  parameter int unsigned SLOTS        = 4,
  parameter int unsigned DEFAULT_RULE = NRULES - 1,
  localparam int unsigned RW  = $clog2(NRULES),
  localparam int unsigned SW  = $clog2(SLOTS),
  localparam int unsigned CW  = SW + 1,
  localparam int unsigned LAT = 2 * SLOTS + 2,
  localparam int unsigned LW  = $clog2(LAT + 1) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SLOTS-1:0]    src_bits_i,
  input  logic [SLOTS*RW-1:0] src_idx_i,
  input  logic [SLOTS-1:0]    src_val_i,
  input  logic [SLOTS-1:0]    dst_bits_i,
  input  logic [SLOTS*RW-1:0] dst_idx_i,
  input  logic [SLOTS-1:0]    dst_val_i,
  input  logic                dc_we_i,
  input  logic                dc_dim_i,
  input  logic [RW-1:0]       dc_addr_i,
  input  logic                dc_bit_i,
  output logic [RW-1:0]       rule_o,
  output logic                hit_o,
  output logic                done_o
);
  localparam logic [RW-1:0] DEF_R = RW'(DEFAULT_RULE);

  fbe_state_t       state_q;
  logic [CW-1:0]    cnt_q;
  logic [LW-1:0]    lat_q;
  logic [SLOTS-1:0] s_bits_q, s_val_q, d_bits_q, d_val_q;
  logic [RW-1:0]    s_idx_q [SLOTS];
  logic [RW-1:0]    d_idx_q [SLOTS];

  logic accept;
  assign accept = (state_q == ST_IDLE) && start_i;

  // ---------------- control and operand capture ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lat_q   <= '0;
    end else begin
      if (state_q != ST_IDLE) lat_q <= lat_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SCAN;
          cnt_q   <= '0;
          lat_q   <= '0;
        end
        ST_SCAN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(2 * SLOTS - 1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s_bits_q <= src_bits_i;
      s_val_q  <= src_val_i;
      d_bits_q <= dst_bits_i;
      d_val_q  <= dst_val_i;
      for (int i = 0; i < int'(SLOTS); i++) begin
        s_idx_q[i] <= src_idx_i[i*RW +: RW];
        d_idx_q[i] <= dst_idx_i[i*RW +: RW];
      end
    end
  end

  // ---------------- slot scan: phase 0 source, phase 1 destination ----------------
  logic [SW-1:0] slot;
  logic          phase;
  logic          own_bit, own_val, issue, cc_match;
  logic [RW-1:0] own_rule;

  assign slot  = cnt_q[SW-1:0];
  assign phase = cnt_q[CW-1];

  always_comb begin
    own_bit  = phase ? d_bits_q[slot] : s_bits_q[slot];
    own_val  = phase ? d_val_q[slot]  : s_val_q[slot];
    own_rule = phase ? d_idx_q[slot]  : s_idx_q[slot];
    issue    = (state_q == ST_SCAN) && own_val && own_bit;
    cc_match = 1'b0;
    for (int y = 0; y < int'(SLOTS); y++)
      if (d_val_q[y] && d_bits_q[y] && d_idx_q[y] == own_rule) cc_match = 1'b1;
    cc_match = cc_match && issue && !phase;
  end

  // probe tag, aligned with the one-cycle memory read
  logic          p_v, p_ph;
  logic [RW-1:0] p_rule;
  always_ff @(posedge clk) begin
    if (rst) begin
      p_v    <= 1'b0;
      p_ph   <= 1'b0;
      p_rule <= '0;
    end else begin
      p_v    <= issue;
      p_ph   <= phase;
      p_rule <= own_rule;
    end
  end

  // ---------------- wildcard memories, index 0 source, 1 destination ----------------
  logic [1:0] wild_q;
  for (genvar d = 0; d < 2; d++) begin : g_dc
    fbe_dc_ram #(.DEPTH(NRULES)) u_ram (
      .clk     (clk),
      .we_i    (dc_we_i && (dc_dim_i == 1'(d))),
      .waddr_i (dc_addr_i),
      .wbit_i  (dc_bit_i),
      .raddr_i (own_rule),
      .rbit_o  (wild_q[d])
    );
  end

  // ---------------- three term minima ----------------
  logic          offer [NTERMS];
  logic [RW-1:0] orule [NTERMS];
  logic          found [NTERMS];
  logic [RW-1:0] mrule [NTERMS];

  assign offer[TERM_CC] = cc_match;
  assign orule[TERM_CC] = own_rule;
  assign offer[TERM_CD] = p_v && !p_ph && wild_q[1];
  assign orule[TERM_CD] = p_rule;
  assign offer[TERM_DC] = p_v && p_ph && wild_q[0];
  assign orule[TERM_DC] = p_rule;

  for (genvar t = 0; t < int'(NTERMS); t++) begin : g_term
    fbe_min_track #(.RW(RW)) u_min (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (accept),
      .offer_i (offer[t]),
      .rule_i  (orule[t]),
      .found_o (found[t]),
      .rule_o  (mrule[t])
    );
  end

  logic          best_f;
  logic [RW-1:0] best_r;
  always_comb begin
    best_f = 1'b0;
    best_r = DEF_R;
    for (int t = 0; t < int'(NTERMS); t++)
      if (found[t] && (!best_f || mrule[t] < best_r)) begin
        best_f = 1'b1;
        best_r = mrule[t];
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rule_o <= DEF_R;
      hit_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= (state_q == ST_FIN);
      if (state_q == ST_FIN) begin
        rule_o <= best_r;
        hit_o  <= best_f;
      end
    end
  end

  // R9: done arrives a fixed number of edges after the accepting edge
  assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_q == LW'(LAT)));
  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10: a probe result only follows a scan cycle
  assert_probe_in_scan_R10: assert property (@(posedge clk) disable iff (rst)
    p_v |-> ($past(state_q) == ST_SCAN));
  // R7: a miss always reports the default rule
  assert_miss_default_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !hit_o) |-> (rule_o == DEF_R));
endmodule

// File: tb/sim_fbe_match_combiner.sv
module sim_fbe_match_combiner;
  localparam int N  = 16;
  localparam int K  = 4;
  localparam int RW = 4;
  localparam int DEF = N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [K-1:0] src_bits_i = '0, src_val_i = '0, dst_bits_i = '0, dst_val_i = '0;
  logic [K*RW-1:0] src_idx_i = '0, dst_idx_i = '0;
  logic dc_we_i = 1'b0, dc_dim_i = 1'b0, dc_bit_i = 1'b0;
  logic [RW-1:0] dc_addr_i = '0;
  logic [RW-1:0] rule_o;
  logic hit_o, done_o;

  int checks = 0;
  int errors = 0;
  bit sw [N];
  bit dw [N];

  always #2 clk = ~clk;

  fbe_match_combiner #(.NRULES(N), .SLOTS(K), .DEFAULT_RULE(DEF)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .src_bits_i(src_bits_i), .src_idx_i(src_idx_i), .src_val_i(src_val_i),
    .dst_bits_i(dst_bits_i), .dst_idx_i(dst_idx_i), .dst_val_i(dst_val_i),
    .dc_we_i(dc_we_i), .dc_dim_i(dc_dim_i), .dc_addr_i(dc_addr_i), .dc_bit_i(dc_bit_i),
    .rule_o(rule_o), .hit_o(hit_o), .done_o(done_o)
  );

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_dc();
    for (int d = 0; d < 2; d++)
      for (int r = 0; r < N; r++) begin
        @(negedge clk);
        dc_we_i = 1'b1; dc_dim_i = 1'(d); dc_addr_i = RW'(r);
        dc_bit_i = d ? dw[r] : sw[r];
      end
    @(negedge clk);
    dc_we_i = 1'b0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < N; r++) begin sw[r] = 0; dw[r] = 0; end
    src_bits_i = '0; src_val_i = '0; dst_bits_i = '0; dst_val_i = '0;
    src_idx_i = '0; dst_idx_i = '0;
  endtask

  task automatic set_slot(input bit dst, input int s, input int r, input bit v, input bit b);
    if (dst) begin
      dst_idx_i[s*RW +: RW] = RW'(r); dst_val_i[s] = v; dst_bits_i[s] = b;
    end else begin
      src_idx_i[s*RW +: RW] = RW'(r); src_val_i[s] = v; src_bits_i[s] = b;
    end
  endtask

  // three-term reference: full expanded AND with the wildcard-by-wildcard part left out
  task automatic ref_eval(output bit h, output int r, output string tag);
    bit es [N];
    bit ed [N];
    for (int i = 0; i < N; i++) begin es[i] = 0; ed[i] = 0; end
    for (int s = 0; s < K; s++) begin
      if (src_val_i[s] && src_bits_i[s]) es[src_idx_i[s*RW +: RW]] = 1;
      if (dst_val_i[s] && dst_bits_i[s]) ed[dst_idx_i[s*RW +: RW]] = 1;
    end
    h = 0; r = DEF; tag = "R7";
    for (int i = N - 1; i >= 0; i--)
      if ((es[i] && ed[i]) || (es[i] && dw[i]) || (sw[i] && ed[i])) begin
        h = 1; r = i;
        tag = (es[i] && ed[i]) ? "R2" : (es[i] && dw[i]) ? "R3" : "R4";
      end
  endtask

  // starts a lookup, returns edges from the accepting edge to done
  task automatic run(output int lat);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin @(negedge clk); lat++; end
  endtask

  task automatic run_check(input string extra);
    bit h; int r; string tag; int lat;
    ref_eval(h, r, tag);
    run(lat);
    chk(lat == 2*K+2, "R9 latency", lat, 2*K+2);
    chk(hit_o == h, {tag, " hit ", extra}, hit_o, h);
    chk(int'(rule_o) == r, {tag, " R6 rule ", extra}, rule_o, r);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 pulse", done_o, 0);
    chk(int'(rule_o) == r, "R9 hold", rule_o, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done_o == 0, "R1 done", done_o, 0);
    chk(hit_o == 0, "R1 hit", hit_o, 0);
    chk(int'(rule_o) == DEF, "R1 rule", rule_o, DEF);
    rst = 1'b0;

    // R7 empty lookup
    clear_all(); load_dc(); run_check("R7 empty");

    // R5 rule wildcarded in both fields only
    clear_all(); sw[3] = 1; dw[3] = 1; load_dc(); run_check("R5 alone");
    chk(hit_o == 0, "R5 no hit", hit_o, 0);
    set_slot(0, 1, 9, 1, 1); set_slot(1, 2, 9, 1, 1); run_check("R5 with R2");
    chk(int'(rule_o) == 9, "R5 rule", rule_o, 9);

    // R6 winner across the three terms
    clear_all(); sw[2] = 1; dw[5] = 1; load_dc();
    set_slot(0, 0, 7, 1, 1); set_slot(1, 3, 7, 1, 1);
    set_slot(0, 2, 5, 1, 1); set_slot(1, 1, 2, 1, 1);
    run_check("R6 mix");
    chk(int'(rule_o) == 2, "R6 lowest", rule_o, 2);

    // R8 invalid slot and clear bit contribute nothing
    clear_all(); load_dc();
    set_slot(0, 0, 1, 0, 1); set_slot(1, 0, 1, 1, 1);
    set_slot(0, 3, 4, 1, 0); set_slot(1, 2, 4, 1, 1);
    run_check("R8");
    chk(hit_o == 0, "R8 no hit", hit_o, 0);

    // R11 rewriting one wildcard bit changes the next result
    clear_all(); load_dc(); set_slot(0, 1, 6, 1, 1); run_check("R11 before");
    @(negedge clk); dc_we_i = 1; dc_dim_i = 1; dc_addr_i = 4'd6; dc_bit_i = 1;
    @(negedge clk); dc_we_i = 0; dw[6] = 1;
    run_check("R11 after");
    chk(hit_o == 1 && rule_o == 4'd6, "R11 rule", rule_o, 6);

    // R10 start and input changes during a lookup are ignored
    begin
      int lat;
      clear_all(); load_dc(); set_slot(0, 0, 8, 1, 1); set_slot(1, 0, 8, 1, 1);
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0; src_val_i = '0; dst_val_i = '0;
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
      lat = 2;
      while (!done_o && lat < 100) begin @(negedge clk); lat++; end
      chk(lat == 2*K+2, "R10 latency", lat, 2*K+2);
      chk(hit_o == 1 && rule_o == 4'd8, "R10 rule", rule_o, 8);
      lat = 0;
      for (int i = 0; i < 3*K; i++) begin @(negedge clk); if (done_o) lat++; end
      chk(lat == 0, "R10 no second done", lat, 0);
    end

    // sweep of random lookups
    for (int t = 0; t < 1500; t++) begin
      clear_all();
      for (int r = 0; r < N; r++) begin
        sw[r] = ($urandom % 5) == 0;
        dw[r] = ($urandom % 5) == 0;
      end
      load_dc();
      for (int s = 0; s < K; s++) begin
        set_slot(0, s, $urandom % N, ($urandom % 4) != 0, ($urandom % 3) != 0);
        set_slot(1, s, $urandom % N, ($urandom % 4) != 0, ($urandom % 3) != 0);
      end
      if (t % 3 == 0) set_slot(1, $urandom % K, src_idx_i[0 +: RW], 1, 1);
      run_check("sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule